// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Block Select

This block is a serial memory target for a two-wire bus, with one clock line and one data line. It holds a 1024 x 8 register array. It runs on the system clock and oversamples the bus lines through a short synchronizer. A START or STOP condition is an edge on the data line while the clock line is high. The block recognises both, takes in an address header, then writes or reads bytes of the array. It pulls the data line low only through an output-enable, so the line is open-drain.

Two bits of the header are never compared with a pin. They are memory address bits that pick one of four 256-byte blocks. An 8-bit word pointer then selects a byte inside that block. After each stored or sent byte, the pointer's 8 bits step forward and wrap within the same block. To read from a chosen address, the master sends a write header and a word byte, then a repeated START and a read header. A master NACK ends a read. The block then stays silent until the next STOP or START.

There is no streaming interface: the bus lines and the address pin are plain control pins. The block never stretches the clock and never holds off the master, so there are no back-pressure rules.

Top module: `i2cee_slave`

## Requirements
- R1: After reset the block does not drive the data line (`sda_oe_o` low), it is idle, and every byte of the array reads 0x00.
- R2: A START is a falling data line while the clock line is high, and a STOP is a rising data line while the clock line is high. A START, repeated or not, always begins a new header and releases the data line. A STOP returns the block to idle with the line released.
- R3: The header is the first byte after a START, sent MSB first. Its bits 7:4 must be 1010 and its bit 3 must equal `addr_pin_i`. When both hold, the block pulls the data line low for the ninth clock.
- R4: A header that fails the R3 match gets no acknowledge. The block then keeps the data line released for every later byte and does not write the array, until the next START.
- R5: Header bits 2:1 select the 256-byte block (bit 2 is the upper block bit). Block and word pointer together form the 10-bit array address {block, pointer}.
- R6: With header bit 0 = 0 (write), the first byte after the header loads the word pointer. Each later byte is stored at {block, pointer}, and the pointer then increments modulo 256. The block acknowledges every byte of a write.
- R7: With header bit 0 = 1 (read), the block sends the byte at {block, pointer}, MSB first, and the pointer then increments modulo 256. A read with no word byte before it continues from the pointer left by the last transfer.
- R8: In a read, the block releases the data line for the ninth clock and samples the master's acknowledge. A low line (ACK) makes it send the next byte. A high line (NACK) makes it stop sending and keep the line released until STOP or START.
- R9: A write header and a word byte, followed by a repeated START and a read header, return data starting at the address just given.
- R10: The block turns its data-line drive on only while the synchronized clock line is low. It turns the drive off only while that line is low, or in the cycle after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Resolved bus data line as seen at the pad |
| addr_pin_i | input | 1 | Strap compared with header bit 3 |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
A bus edge takes two synchronizer stages plus one edge register before the controller sees it. Any change of `sda_oe_o` caused by a falling clock line therefore appears three system clocks after that fall. The bench master holds each clock-line phase for ten system clocks and changes its own data bit three clocks into the low phase. It samples the data line, whether acknowledge or read data, at the middle of the high phase, well after the three-cycle lag has passed. Written bytes are checked by reading them back through later bus transfers. The bench's own model of the array and pointer gives the expected values, and it is updated on the same rules as R5 to R7.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  localparam int BYTE_W = 8;
  localparam int BLK_W  = 2;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_OUT, ST_TX, ST_ACK_IN, ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    K_HDR, K_WORD, K_DATA
  } kind_e;
endpackage

// File: rtl/i2cee_sampler.sv
module i2cee_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[STAGES-2:0], sda_i};
      scl_d    <= scl_sync[STAGES-1];
      sda_d    <= sda_sync[STAGES-1];
    end
  end

  assign scl_q    = scl_sync[STAGES-1];
  assign sda_q    = sda_sync[STAGES-1];
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_p  = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_p   = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2cee_mem.sv
module i2cee_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
    end else if (we) begin
      arr[waddr] <= wdata;
    end
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter int AW = BLK_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              sda_q,
  input  logic              addr_pin,
  input  logic [BYTE_W-1:0] rdata,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic [AW-1:0]     raddr,
  output logic              sda_oe,
  output st_e               st
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  kind_e             kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txsh, ptr;
  logic [BLK_W-1:0]  blk;
  logic              rw, m_ack;
  logic              hdr_ok;

  assign raddr  = {blk, ptr};
  assign hdr_ok = (shreg[7:4] == DEV_ID) && (shreg[3] == addr_pin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_HDR; cnt <= '0;
      shreg <= '0; txsh <= '0; ptr <= '0; blk <= '0;
      rw <= 1'b0; m_ack <= 1'b0; sda_oe <= 1'b0;
      we <= 1'b0; waddr <= '0; wdata <= '0;
    end else begin
      we <= 1'b0;
      if (start_p) begin
        st <= ST_RX; kind <= K_HDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_p) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_q};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              case (kind)
                K_HDR: begin
                  if (hdr_ok) begin
                    blk <= shreg[2:1]; rw <= shreg[0];
                    sda_oe <= 1'b1; st <= ST_ACK_OUT;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                K_WORD: begin
                  ptr <= shreg; sda_oe <= 1'b1; st <= ST_ACK_OUT;
                end
                default: begin
                  we <= 1'b1; waddr <= {blk, ptr}; wdata <= shreg;
                  ptr <= ptr + 1'b1; sda_oe <= 1'b1; st <= ST_ACK_OUT;
                end
              endcase
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              if (kind == K_HDR && rw) begin
                txsh <= rdata; sda_oe <= ~rdata[BYTE_W-1];
                ptr <= ptr + 1'b1; cnt <= '0; st <= ST_TX;
              end else begin
                sda_oe <= 1'b0; st <= ST_RX; cnt <= '0;
                kind <= (kind == K_HDR) ? K_WORD : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0; st <= ST_ACK_IN;
              end else begin
                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txsh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              m_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (m_ack) begin
                txsh <= rdata; sda_oe <= ~rdata[BYTE_W-1];
                ptr <= ptr + 1'b1; cnt <= '0; st <= ST_TX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_pin_i,
  output logic sda_oe_o
);
  localparam int AW = BLK_W + BYTE_W;

  logic scl_q, sda_q, scl_rise, scl_fall, start_p, stop_p;
  logic we;
  logic [AW-1:0] waddr, raddr;
  logic [BYTE_W-1:0] wdata, rdata;
  st_e st;

  i2cee_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2cee_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_q(sda_q), .addr_pin(addr_pin_i),
    .rdata(rdata), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr),
    .sda_oe(sda_oe_o), .st(st)
  );

  i2cee_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: rtl/i2cee_slave_chk.sv
module i2cee_slave_chk
  import i2cee_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic start_p,
  input logic stop_p,
  input logic sda_oe_o,
  input st_e  st
);
  p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_q);

  p_oe_fall_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> (!scl_q || $past(start_p) || $past(stop_p)));

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (st == ST_IDLE && !sda_oe_o));

  p_start_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st == ST_RX && !sda_oe_o));

  p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe_o);

  p_ackin_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK_IN) |-> !sda_oe_o);
endmodule

bind i2cee_slave i2cee_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_p(start_p),
  .stop_p(stop_p), .sda_oe_o(sda_oe_o), .st(st)
);

// File: tb/i2cee_slave_tb_top.sv
module i2cee_slave_tb_top;
  localparam int HP = 10;
  localparam logic PIN = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_o;
  logic sda_line;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] model [1024];
  logic [7:0] mptr = 8'h00;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe_o;

  i2cee_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pin_i(PIN), .sda_oe_o(sda_oe_o)
  );

  function automatic logic [7:0] hdr(input logic [1:0] blk, input logic rd);
    return {4'b1010, PIN, blk, rd};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    if (scl_m == 1'b0) begin
      tick(3); sda_m = 1'b1; tick(HP - 3); scl_m = 1'b1; tick(HP);
    end
    sda_m = 1'b0; tick(HP); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(3); sda_m = 1'b0; tick(HP - 3); scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(3); sda_m = b[i]; tick(HP - 3); scl_m = 1'b1; tick(HP); scl_m = 1'b0;
    end
    tick(3); sda_m = 1'b1; tick(HP - 3); scl_m = 1'b1; tick(HP / 2);
    ack = ~sda_line;
    tick(HP / 2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    d = 8'h00;
    tick(3); sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(HP - 3); scl_m = 1'b1; tick(HP / 2);
      d = {d[6:0], sda_line};
      tick(HP / 2); scl_m = 1'b0; tick(3);
    end
    sda_m = ~give_ack; tick(HP - 3); scl_m = 1'b1; tick(HP); scl_m = 1'b0;
    tick(3); sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [1:0] blk, input logic [7:0] word, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(hdr(blk, 1'b0), ack); chk(ack, "R3 write header ack", ack, 1);
    send_byte(word, ack);           chk(ack, "R6 word byte ack", ack, 1);
    mptr = word;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk(ack, "R6 data byte ack", ack, 1);
      model[{blk, mptr}] = d;
      mptr = mptr + 8'd1;
    end
    bus_stop();
    chk(sda_line == 1'b1, "R2 line released after stop", sda_line, 1);
  endtask

  task automatic rd_bytes(input logic [1:0] blk, input int n, input string req);
    logic [7:0] d, e;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      e = model[{blk, mptr}];
      mptr = mptr + 8'd1;
      chk(d == e, req, d, e);
    end
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R8 silent after NACK", d, 8'hFF);
  endtask

  task automatic rd_txn(input logic [1:0] blk, input logic [7:0] word, input int n);
    logic ack;
    bus_start();
    send_byte(hdr(blk, 1'b0), ack); chk(ack, "R3 header ack", ack, 1);
    send_byte(word, ack);           chk(ack, "R6 word ack", ack, 1);
    mptr = word;
    bus_start();
    send_byte(hdr(blk, 1'b1), ack); chk(ack, "R9 read header ack", ack, 1);
    rd_bytes(blk, n, "R9 R7 R5 read data");
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 8'h00;
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    void'($urandom(32'd1234));
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe_o == 1'b0, "R1 released after reset", sda_oe_o, 0);
    rd_txn(2'd0, 8'h05, 2);              // R1 zero contents

    // R4: wrong device id, nothing acked nor written
    bus_start();
    send_byte({4'b1011, PIN, 2'd1, 1'b0}, ack); chk(!ack, "R4 bad id no ack", ack, 0);
    send_byte(8'h10, ack); chk(!ack, "R4 word ignored", ack, 0);
    send_byte(8'hAA, ack); chk(!ack, "R4 data ignored", ack, 0);
    bus_stop();
    // R3: pin bit mismatch
    bus_start();
    send_byte({4'b1010, ~PIN, 2'd1, 1'b0}, ack); chk(!ack, "R3 pin mismatch no ack", ack, 0);
    send_byte(8'h10, ack); chk(!ack, "R4 word ignored pin", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R4 data ignored pin", ack, 0);
    bus_stop();
    rd_txn(2'd1, 8'h10, 1);              // R4 unchanged

    // R6/R7 wrap within block 3
    wr_txn(2'd3, 8'hFE, 4);
    rd_txn(2'd3, 8'hFE, 4);

    // R5: same word in every block differs
    for (int b = 0; b < 4; b++) wr_txn(2'(b), 8'h40, 1);
    for (int b = 0; b < 4; b++) rd_txn(2'(b), 8'h40, 1);

    // random traffic
    for (int k = 0; k < 10; k++) begin
      logic [1:0] b;
      logic [7:0] w;
      b = 2'($urandom);
      w = 8'($urandom);
      wr_txn(b, w, 1 + int'($urandom % 5));
      rd_txn(2'($urandom), 8'($urandom), 1 + int'($urandom % 4));
      rd_txn(b, w, 3);
    end

    // R7 current-address read continues from pointer
    rd_txn(2'd2, 8'h30, 2);
    bus_start();
    send_byte(hdr(2'd2, 1'b1), ack); chk(ack, "R7 current read ack", ack, 1);
    rd_bytes(2'd2, 3, "R7 current read data");
    bus_stop();
    chk(sda_oe_o == 1'b0, "R2 idle after stop", sda_oe_o, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule